// File: doc/BRIEF.md
# Radix-4 Booth Multiply-Accumulate Unit

This block multiplies two signed 8-bit two's-complement operands and adds the product into a 24-bit signed running sum. The multiplier operand is recoded into four radix-4 Booth digits, each in {-2, -1, 0, +1, +2}. Each digit selects one partial-product row. The rows are compressed by carry-save stages down to a sum row and a carry row. The same datapath serves positive and negative operands.

The two remaining rows are added by an iterative carry-settling adder. That adder repeats half-additions of the sum and carry words until no carry is left, so its latency depends on the data. The same adder then adds the sign-extended product to the running sum, or to zero when the clear flag came with the operands. A client presents operands with a valid/ready handshake. It waits for a one-cycle done pulse, and in that cycle the new sum is visible on the output. Successive operations are not overlapped.

Top module: `booth_mac`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, acc_out is 0, in_ready is 1 and done is 0.
- R2: An operation is accepted at a rising clock edge where in_valid and in_ready are both 1. From the next cycle until the done cycle, in_ready is 0, and in_valid, in_a, in_b and in_clr are ignored.
- R3: done is 1 for exactly one cycle per accepted operation. In that cycle acc_out already shows the new sum and in_ready is 1 again.
- R4: With in_clr = 0, the new acc_out is the previous acc_out plus the signed product in_a * in_b, sign-extended to 24 bits.
- R5: With in_clr = 1, the new acc_out equals the sign-extended product alone, and the previous sum is discarded.
- R6: The most negative operand value -128 is handled on either input. For example, -128 * -128 gives +16384 and -128 * 127 gives -16256.
- R7: While the block is idle and in_valid is 0, acc_out holds its value and done stays 0.
- R8: The running sum wraps modulo 2^24. For example, 512 additions of +16384 starting from 0 give -8388608.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is presented |
| in_ready | output | 1 | Block is idle and can accept operands |
| in_a | input | 8 | Signed multiplicand |
| in_b | input | 8 | Signed multiplier, Booth-recoded |
| in_clr | input | 1 | Start a fresh sum with this product |
| acc_out | output | 24 | Signed running sum |
| done | output | 1 | One-cycle pulse when acc_out is updated |

## Verification
The assertions assume that a client never relies on operands presented while in_ready is low. They also assume that in_valid is driven to a known level in every cycle after reset, since the idle-hold property treats in_valid low as "nothing offered". The bench drives every input on the falling edge and holds in_valid high only for one accepting edge. The one exception is the busy-ignore scenario, which deliberately keeps in_valid high with unrelated operands during the busy window and drops it as soon as done is seen. Random operand runs mix clear and accumulate steps and include -128 on both inputs.

// File: rtl/bmac_pkg.sv
// Package: shared sizes and controller state type for the Booth MAC.
// Assumes an even operand width so that the radix-4 digit count is exact.
package bmac_pkg;
    localparam int OP_W  = 8;
    localparam int ACC_W = 24;
    localparam int NDIG  = OP_W / 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2
    } mac_state_e;
endpackage

// File: rtl/booth_pp_gen.sv
// Radix-4 Booth recoder and partial-product row builder.
// Each overlapping 3-bit group of the multiplier (bit -1 is taken as 0)
// selects 0, +/-M or +/-2M. Rows are sign-extended to ROW_W and
// pre-shifted by two bits per digit. Assumes ROW_W >= 2*OP_W.
module booth_pp_gen #(
    parameter int OP_W  = bmac_pkg::OP_W,
    parameter int ROW_W = bmac_pkg::ACC_W,
    localparam int NDIG = OP_W / 2
) (
    input  logic [OP_W-1:0]              mcand,
    input  logic [OP_W-1:0]              mplier,
    output logic [NDIG-1:0][ROW_W-1:0]   rows
);
    logic [OP_W:0]      mplier_ext;
    logic [ROW_W-1:0]   mcand_ext;

    assign mplier_ext = {mplier, 1'b0};
    assign mcand_ext  = {{(ROW_W-OP_W){mcand[OP_W-1]}}, mcand};

    for (genvar gi = 0; gi < NDIG; gi++) begin : g_digit
        logic [2:0]       grp;
        logic             sel_one, sel_two, neg;
        logic [ROW_W-1:0] mag, signed_row;

        assign grp = mplier_ext[2*gi+2 -: 3];

        // Digit decode: magnitude select and sign of this Booth digit.
        always_comb begin
            sel_one = grp[1] ^ grp[0];
            sel_two = (grp == 3'b011) || (grp == 3'b100);
            neg     = grp[2] & ~(grp[1] & grp[0]);
        end

        // Row value: chosen multiple, negated when the digit is negative.
        always_comb begin
            if (sel_one)      mag = mcand_ext;
            else if (sel_two) mag = mcand_ext << 1;
            else              mag = '0;
            signed_row = neg ? (~mag + ROW_W'(1)) : mag;
        end

        assign rows[gi] = signed_row << (2 * gi);
    end
endmodule

// File: rtl/csa_reduce.sv
// Carry-save reduction of ROWS rows to a sum row and a carry row.
// Each 3:2 stage forms a bitwise XOR sum and a majority carry moved up
// one place; no carry travels along a stage. Assumes ROWS >= 3.
module csa_reduce #(
    parameter int ROWS = bmac_pkg::NDIG,
    parameter int W    = bmac_pkg::ACC_W,
    localparam int NST = ROWS - 2
) (
    input  logic [ROWS-1:0][W-1:0] rows,
    output logic [W-1:0]           sum_row,
    output logic [W-1:0]           carry_row
);
    logic [NST:0][W-1:0] s_lvl;
    logic [NST:0][W-1:0] c_lvl;

    assign s_lvl[0] = rows[0];
    assign c_lvl[0] = rows[1];

    for (genvar gk = 0; gk < NST; gk++) begin : g_stage
        logic [W-1:0] t;
        assign t             = rows[gk+2];
        assign s_lvl[gk+1]   = s_lvl[gk] ^ c_lvl[gk] ^ t;
        assign c_lvl[gk+1]   = ((s_lvl[gk] & c_lvl[gk]) |
                                (s_lvl[gk] & t) |
                                (c_lvl[gk] & t)) << 1;
    end

    assign sum_row   = s_lvl[NST];
    assign carry_row = c_lvl[NST];
endmodule

// File: rtl/iter_adder.sv
// Iterative carry-settling adder. On start it loads the half-add of a and b;
// then each cycle it half-adds the sum word and the carry word until the
// carry word is zero. fin is high while the result is settled and unread.
// The result is modulo 2^W. A start while busy restarts the adder.
module iter_adder #(
    parameter int W = bmac_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         fin
);
    logic [W-1:0] s_q, c_q;
    logic         run_q;

    // Load operands on start, otherwise iterate until carries are gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q   <= '0;
            c_q   <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            s_q   <= a ^ b;
            c_q   <= (a & b) << 1;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (c_q == '0) begin
                run_q <= 1'b0;
            end else begin
                s_q <= s_q ^ c_q;
                c_q <= (s_q & c_q) << 1;
            end
        end
    end

    assign sum = s_q;
    assign fin = run_q && (c_q == '0);
endmodule

// File: rtl/booth_mac.sv
// Top: signed Booth multiply-accumulate with a valid/ready operand handshake.
// Accept -> product add (iterative) -> accumulate add (same adder) -> done.
// Assumes in_clr is sampled together with the operands at acceptance.
module booth_mac #(
    parameter int OP_W  = bmac_pkg::OP_W,
    parameter int ACC_W = bmac_pkg::ACC_W,
    localparam int NDIG = OP_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_b,
    input  logic             in_clr,
    output logic [ACC_W-1:0] acc_out,
    output logic             done
);
    import bmac_pkg::*;

    mac_state_e                  state_q;
    logic                        clr_q;
    logic [ACC_W-1:0]            acc_q;
    logic                        done_q;
    logic [NDIG-1:0][ACC_W-1:0]  pp_rows;
    logic [ACC_W-1:0]            row_s, row_c;
    logic [ACC_W-1:0]            add_a, add_b, add_sum;
    logic                        add_start, add_fin, fire;

    booth_pp_gen #(.OP_W(OP_W), .ROW_W(ACC_W)) u_pp (
        .mcand  (in_a),
        .mplier (in_b),
        .rows   (pp_rows)
    );

    csa_reduce #(.ROWS(NDIG), .W(ACC_W)) u_csa (
        .rows      (pp_rows),
        .sum_row   (row_s),
        .carry_row (row_c)
    );

    iter_adder #(.W(ACC_W)) u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .start (add_start),
        .a     (add_a),
        .b     (add_b),
        .sum   (add_sum),
        .fin   (add_fin)
    );

    assign in_ready = (state_q == ST_IDLE);
    assign fire     = in_valid && in_ready;

    // Adder operand select: product rows at acceptance, then product + base.
    always_comb begin
        add_start = 1'b0;
        add_a     = row_s;
        add_b     = row_c;
        if (state_q == ST_IDLE) begin
            add_start = fire;
        end else if (state_q == ST_MUL) begin
            add_start = add_fin;
            add_a     = add_sum;
            add_b     = clr_q ? '0 : acc_q;
        end
    end

    // Controller: sequence the two additions and update the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            clr_q   <= 1'b0;
            acc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (fire) begin
                    clr_q   <= in_clr;
                    state_q <= ST_MUL;
                end
                ST_MUL: if (add_fin) state_q <= ST_ACC;
                ST_ACC: if (add_fin) begin
                    acc_q   <= add_sum;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign acc_out = acc_q;
    assign done    = done_q;
endmodule

// File: rtl/bmac_chk.sv
// Checker for booth_mac: handshake, done pulse and idle hold properties.
// Assumes in_valid is known in every cycle after reset.
module bmac_chk #(
    parameter int ACC_W = bmac_pkg::ACC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [ACC_W-1:0] acc_out,
    input logic             done
);
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready); // R3
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(in_ready)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> ($stable(acc_out) && !done)); // R7
endmodule

bind booth_mac bmac_chk #(.ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .acc_out  (acc_out),
    .done     (done)
);

// File: tb/booth_mac_tb_top.sv
`timescale 1ns/1ps
module booth_mac_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_clr;
    logic [7:0]  in_a, in_b;
    logic        in_ready, done;
    logic [23:0] acc_out;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [23:0] model  = '0;

    always #2.5 clk = ~clk;

    booth_mac dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_clr(in_clr), .acc_out(acc_out), .done(done)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One operation: present at negedge, expect busy, wait for done, compare.
    task automatic do_op(input logic [7:0] a, input logic [7:0] b, input logic clr,
                         input bit keep_valid, input bit chk_each);
        int p;
        int cyc;
        p = $signed(a) * $signed(b);
        model = (clr ? 24'd0 : model) + 24'(p);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_clr = clr;
        @(negedge clk);
        if (keep_valid) begin
            in_a = ~a; in_b = b ^ 8'h5a; in_clr = ~clr;
        end else begin
            in_valid = 1'b0;
        end
        if (chk_each) check("R2 busy", {23'd0, in_ready}, 24'd0);
        cyc = 0;
        while (done !== 1'b1 && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        if (chk_each || cyc >= 200) begin
            check("R3 done seen", {23'd0, done}, 24'd1);
            check("R3 ready at done", {23'd0, in_ready}, 24'd1);
        end
        if (chk_each) check(clr ? "R5 clear result" : "R4 accumulate", acc_out, model);
        @(negedge clk);
        if (chk_each) check("R3 single pulse", {23'd0, done}, 24'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 acc at reset", acc_out, 24'd0);
        check("R1 ready at reset", {23'd0, in_ready}, 24'd1);
        check("R1 done at reset", {23'd0, done}, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after reset", acc_out, 24'd0);
        model = '0;
    endtask

    task automatic t_directed;
        do_op(8'd3, 8'd5, 1'b1, 0, 1);
        do_op(8'hfd, 8'd7, 1'b0, 0, 1);     // -3*7
        do_op(8'd9, 8'hf8, 1'b0, 0, 1);     // 9*-8
        do_op(8'hf6, 8'hf1, 1'b0, 0, 1);    // -10*-15
        do_op(8'd0, 8'd77, 1'b0, 0, 1);
        do_op(8'd127, 8'd127, 1'b0, 0, 1);
    endtask

    task automatic t_clear;
        do_op(8'd100, 8'd100, 1'b0, 0, 1);
        do_op(8'd2, 8'hff, 1'b1, 0, 1);     // R5: sum becomes -2
        check("R5 clear value", acc_out, 24'hfffffe);
    endtask

    task automatic t_most_negative;
        do_op(8'h80, 8'h80, 1'b1, 0, 1);    // R6
        check("R6 -128*-128", acc_out, 24'd16384);
        do_op(8'h80, 8'h7f, 1'b1, 0, 1);
        check("R6 -128*127", acc_out, 24'hffc080);
        do_op(8'h7f, 8'h80, 1'b0, 0, 1);
        do_op(8'h80, 8'h01, 1'b0, 0, 1);
    endtask

    task automatic t_idle_hold;
        logic [23:0] held;
        held = acc_out;
        in_a = 8'h55; in_b = 8'h33; in_clr = 1'b1; in_valid = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R7 idle done low", {23'd0, done}, 24'd0);
        end
        check("R7 idle hold", acc_out, held);
    endtask

    task automatic t_busy_ignore;
        do_op(8'd11, 8'd13, 1'b0, 1, 1);    // R2: garbage held during busy
        check("R2 ignored while busy", acc_out, model);
        check("R2 ready after", {23'd0, in_ready}, 24'd1);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a, b;
            logic c;
            a = 8'($urandom);
            b = 8'($urandom);
            if (i % 37 == 5) a = 8'h80;
            if (i % 41 == 9) b = 8'h80;
            c = ($urandom % 16) == 0;
            do_op(a, b, c, 0, 0);
            check("R4 random accumulate", acc_out, model);
        end
    endtask

    task automatic t_wrap;
        do_op(8'h80, 8'h80, 1'b1, 0, 0);
        for (int i = 1; i < 512; i++) do_op(8'h80, 8'h80, 1'b0, 0, 0);
        check("R8 wrap", acc_out, 24'h800000);
        do_op(8'h80, 8'h80, 1'b0, 0, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_directed();
        t_clear();
        t_most_negative();
        t_idle_hold();
        t_busy_ignore();
        t_random();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule